// File: doc/BRIEF.md
# Scroll and Toggle LED Mode Controller

This block drives a row of four indicator LEDs in one of two modes. After reset it is in scroll mode: a single lit LED moves one place at a time, at a fixed step period, and a direction input chooses whether it climbs toward the highest index or descends toward index 0. A press event on any of the four button inputs switches the block into toggle mode. In that mode the LEDs are cleared, and each later press event flips the LED that belongs to the pressed button.

An idle timer runs while the block is in toggle mode. Every press event restarts it. When a full timeout interval passes with no press, the block goes back to scroll mode. Scrolling resumes from the position it held when it left, and a new full step period starts. The toggle states and the upper bits of the idle timer are output so that they can be shown on a display. The press inputs are single-cycle event pulses that an upstream sensing stage produces. The step period and the timeout are parameters given in clock cycles.

Top module: `led_mode_ctrl`

## Requirements
- R1: While reset is high and in the cycle after reset is released, `toggle_mode_o` is 0, `led_o` is 4'b0001, `toggle_o` is 0 and `timer_o` is 0.
- R2: In scroll mode with `dir_i` = 0, the lit LED moves from index i to index (i+1) mod 4 every STEP_CYCLES clock edges, and exactly one LED is lit. The first move comes STEP_CYCLES edges after reset release.
- R3: In scroll mode with `dir_i` = 1, the lit LED moves from index i to index (i-1) mod 4 at the same pace.
- R4: A nonzero `press_i` sampled in scroll mode sets `toggle_mode_o` to 1 at that edge and clears `led_o` and `toggle_o` to 0. The entering press flips no LED, so toggle states are cleared on every entry.
- R5: In toggle mode, each edge that samples `press_i` replaces `toggle_o` with `toggle_o` XOR `press_i`, where bit k belongs to button k. `led_o` equals `toggle_o`.
- R6: In toggle mode, after TIMEOUT_CYCLES consecutive edges with no press, the block returns to scroll mode. `led_o` then shows the scroll position held at entry, and the next move comes STEP_CYCLES edges later.
- R7: A press in toggle mode restarts the idle count at 0. This includes a press on the edge that would otherwise end the timeout.
- R8: `timer_o` shows bits [CW-1:CW-4] of the idle count, where CW = clog2(TIMEOUT_CYCLES). It is 0 in scroll mode.
- R9: `dir_i` has no effect while in toggle mode, because the scroll position is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| press_i | input | 4 | Press-event pulses, bit k for button k |
| dir_i | input | 1 | Scroll direction: 0 toward higher index, 1 toward lower index |
| led_o | output | 4 | LED drive, 1 = lit |
| toggle_o | output | 4 | Current toggle states |
| timer_o | output | 4 | Upper bits of the idle count |
| toggle_mode_o | output | 1 | 1 in toggle mode, 0 in scroll mode |

## Verification
All outputs are registers, so a press sampled at an edge shows its full effect (mode change, toggle flip, timer restart) right after that same edge. The bench applies each press for exactly one edge and samples on the following falling edge. Scroll moves are due exactly STEP_CYCLES edges after reset release, after the previous move, or after a return from toggle mode. The timeout return is due at the TIMEOUT_CYCLES-th press-free edge. The bench counts edges precisely and checks both one edge before and at each due edge, so that an early or late move or return is caught.

// File: rtl/led_mode_pkg.sv
package led_mode_pkg;
  typedef enum logic {
    MODE_SCROLL = 1'b0,
    MODE_TOGGLE = 1'b1
  } led_mode_e;
endpackage

// File: rtl/step_pacer.sv
// Free-running step counter; emits a one-cycle tick every STEP_CYCLES edges while run is high.
module step_pacer #(
  parameter int STEP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ring_shifter.sv
// One-hot position register that rotates by one place when advanced.
module ring_shifter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         dir,
  output logic [N-1:0] ring_q,
  output logic [N-1:0] ring_nxt
);
  for (genvar i = 0; i < N; i++) begin : g_rot
    localparam int LO = (i + N - 1) % N;
    localparam int HI = (i + 1) % N;
    assign ring_nxt[i] = !adv ? ring_q[i] : (dir ? ring_q[HI] : ring_q[LO]);
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= N'(1);
    else     ring_q <= ring_nxt;
  end
endmodule

// File: rtl/idle_timer.sv
// Counts idle edges while run is high; restart clears, expire fires on the last count.
module idle_timer #(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int SW             = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  output logic          expire,
  output logic [SW-1:0] level
);
  localparam int CW = (TIMEOUT_CYCLES > (1 << SW)) ? $clog2(TIMEOUT_CYCLES) : SW;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && !restart && (cnt_q == LAST);
  assign level  = cnt_q[CW-1 -: SW];

  always_ff @(posedge clk) begin
    if (rst || !run || restart || expire) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl
  import led_mode_pkg::*;
#(
  parameter int N_LED          = 4,
  parameter int STATUS_W       = 4,
  parameter int STEP_CYCLES    = 25_000_000,
  parameter int TIMEOUT_CYCLES = 500_000_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_LED-1:0]    press_i,
  input  logic                dir_i,
  output logic [N_LED-1:0]    led_o,
  output logic [N_LED-1:0]    toggle_o,
  output logic [STATUS_W-1:0] timer_o,
  output logic                toggle_mode_o
);
  led_mode_e       mode_q, mode_d;
  logic [N_LED-1:0] tog_q, tog_d, ring_q, ring_nxt;
  logic             press_any, in_toggle, step_tick, idle_expire;

  assign press_any = |press_i;
  assign in_toggle = (mode_q == MODE_TOGGLE);

  step_pacer #(.STEP_CYCLES(STEP_CYCLES)) u_pacer (
    .clk (clk),
    .rst (rst),
    .run (!in_toggle),
    .tick(step_tick)
  );

  ring_shifter #(.N(N_LED)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .adv     (step_tick && !press_any),
    .dir     (dir_i),
    .ring_q  (ring_q),
    .ring_nxt(ring_nxt)
  );

  idle_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .SW(STATUS_W)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .run    (in_toggle),
    .restart(press_any),
    .expire (idle_expire),
    .level  (timer_o)
  );

  always_comb begin
    mode_d = mode_q;
    tog_d  = tog_q;
    if (!in_toggle) begin
      if (press_any) begin
        mode_d = MODE_TOGGLE;
        tog_d  = '0;
      end
    end else begin
      tog_d = tog_q ^ press_i;
      if (idle_expire) mode_d = MODE_SCROLL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SCROLL;
      tog_q  <= '0;
      led_o  <= N_LED'(1);
    end else begin
      mode_q <= mode_d;
      tog_q  <= tog_d;
      led_o  <= (mode_d == MODE_TOGGLE) ? tog_d : ring_nxt;
    end
  end

  assign toggle_o      = tog_q;
  assign toggle_mode_o = in_toggle;
  // ring_q is held in the shifter and feeds ring_nxt; no direct use here.
  logic unused_ring;
  assign unused_ring = ^ring_q;
endmodule

// File: rtl/led_mode_chk.sv
module led_mode_chk #(
  parameter int N_LED    = 4,
  parameter int STATUS_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [N_LED-1:0]    press_i,
  input logic [N_LED-1:0]    led_o,
  input logic [N_LED-1:0]    toggle_o,
  input logic [STATUS_W-1:0] timer_o,
  input logic                toggle_mode_o
);
  assert_one_lit_R2: assert property (@(posedge clk) disable iff (rst)
    !toggle_mode_o |-> $countones(led_o) == 1);

  assert_entry_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (!toggle_mode_o && |press_i) |=> (toggle_mode_o && led_o == '0 && toggle_o == '0));

  assert_press_flips_R5: assert property (@(posedge clk) disable iff (rst)
    (toggle_mode_o && |press_i) |=> (toggle_o == ($past(toggle_o) ^ $past(press_i))));

  assert_led_follows_R5: assert property (@(posedge clk) disable iff (rst)
    toggle_mode_o |-> led_o == toggle_o);

  assert_press_restarts_R7: assert property (@(posedge clk) disable iff (rst)
    (toggle_mode_o && |press_i) |=> (toggle_mode_o && timer_o == '0));

  assert_timer_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !toggle_mode_o |-> timer_o == '0);
endmodule

bind led_mode_ctrl led_mode_chk #(.N_LED(N_LED), .STATUS_W(STATUS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .press_i      (press_i),
  .led_o        (led_o),
  .toggle_o     (toggle_o),
  .timer_o      (timer_o),
  .toggle_mode_o(toggle_mode_o)
);

// File: tb/tb_led_mode_ctrl.sv
module tb_led_mode_ctrl;
  localparam int STEP = 8;
  localparam int TMO  = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] press_i = '0;
  logic       dir_i = 1'b0;
  logic [3:0] led_o, toggle_o, timer_o;
  logic       toggle_mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  led_mode_ctrl #(.N_LED(4), .STATUS_W(4), .STEP_CYCLES(STEP), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst(rst), .press_i(press_i), .dir_i(dir_i),
    .led_o(led_o), .toggle_o(toggle_o), .timer_o(timer_o), .toggle_mode_o(toggle_mode_o)
  );

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; press_i = '0; dir_i = 1'b0;
    edges(3);
    rst = 1'b0;
  endtask

  task automatic press(input logic [3:0] p);
    press_i = p;
    edges(1);
    press_i = '0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; edges(2);
    chk("R1", "mode in reset", {3'b0, toggle_mode_o}, 4'b0000);
    chk("R1", "led in reset", led_o, 4'b0001);
    rst = 1'b0;
    chk("R1", "led after release", led_o, 4'b0001);
    chk("R1", "toggles after release", toggle_o, 4'b0000);
    chk("R1", "timer after release", timer_o, 4'b0000);
  endtask

  task automatic t_scroll_up();
    do_reset();
    edges(STEP - 1); chk("R2", "before first step", led_o, 4'b0001);
    edges(1);        chk("R2", "first step", led_o, 4'b0010);
    edges(STEP);     chk("R2", "second step", led_o, 4'b0100);
    edges(STEP);     chk("R2", "third step", led_o, 4'b1000);
    edges(STEP - 1); chk("R2", "hold before wrap", led_o, 4'b1000);
    edges(1);        chk("R2", "wrap to 0", led_o, 4'b0001);
  endtask

  task automatic t_scroll_down();
    do_reset();
    dir_i = 1'b1;
    edges(STEP);     chk("R3", "wrap down", led_o, 4'b1000);
    edges(STEP);     chk("R3", "step down", led_o, 4'b0100);
    dir_i = 1'b0;
    edges(STEP);     chk("R3", "reversed back up", led_o, 4'b1000);
  endtask

  task automatic t_enter_toggle();
    do_reset();
    edges(STEP); chk("R2", "pre-entry position", led_o, 4'b0010);
    press(4'b0100);
    chk("R4", "mode after entry", {3'b0, toggle_mode_o}, 4'b0001);
    chk("R4", "led cleared on entry", led_o, 4'b0000);
    chk("R4", "toggles cleared on entry", toggle_o, 4'b0000);
    press(4'b0001);
    chk("R5", "toggle b0", toggle_o, 4'b0001);
    chk("R5", "led follows", led_o, 4'b0001);
    press(4'b1001);
    chk("R5", "two buttons", toggle_o, 4'b1000);
    press(4'b0001);
    chk("R5", "b0 again", led_o, 4'b1001);
    // timeout from last press
    edges(20);       chk("R8", "timer level at 20", timer_o, 4'd5);
    edges(TMO - 21); chk("R8", "timer level at 63", timer_o, 4'd15);
    chk("R6", "still toggle at 63", {3'b0, toggle_mode_o}, 4'b0001);
    edges(1);
    chk("R6", "returned to scroll", {3'b0, toggle_mode_o}, 4'b0000);
    chk("R6", "scroll position kept", led_o, 4'b0010);
    chk("R8", "timer zero in scroll", timer_o, 4'd0);
    edges(STEP - 1); chk("R6", "no early step", led_o, 4'b0010);
    edges(1);        chk("R6", "step after full period", led_o, 4'b0100);
  endtask

  task automatic t_restart();
    do_reset();
    press(4'b1000);
    edges(60);
    press(4'b0010);
    chk("R7", "timer restarted", timer_o, 4'd0);
    chk("R7", "toggle on restart press", toggle_o, 4'b0010);
    edges(TMO - 1);
    chk("R7", "alive at last idle edge", {3'b0, toggle_mode_o}, 4'b0001);
    press(4'b0100);
    chk("R7", "press on final edge keeps mode", {3'b0, toggle_mode_o}, 4'b0001);
    chk("R7", "timer zero after final press", timer_o, 4'd0);
    chk("R5", "toggles after final press", toggle_o, 4'b0110);
    edges(TMO);
    chk("R6", "timeout after restart", {3'b0, toggle_mode_o}, 4'b0000);
  endtask

  task automatic t_dir_ignored();
    do_reset();
    edges(STEP);
    press(4'b1111);
    chk("R4", "entry press flips nothing", toggle_o, 4'b0000);
    press(4'b0011);
    dir_i = 1'b1;
    edges(STEP * 2);
    chk("R9", "led unchanged by dir", led_o, 4'b0011);
    edges(TMO - STEP * 2);
    chk("R9", "position held through toggle", led_o, 4'b0010);
    edges(STEP);
    chk("R9", "dir applies after return", led_o, 4'b0001);
    press(4'b0001);
    chk("R4", "toggles cleared on re-entry", toggle_o, 4'b0000);
    chk("R4", "led cleared on re-entry", led_o, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_scroll_up();
    t_scroll_down();
    t_enter_toggle();
    t_restart();
    t_dir_ignored();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule